// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with Byte Register Interface

The block is a watchdog countdown for a larger chip. Software reaches it through a small byte-wide register window: a control byte whose lowest bit arms the timer, a kick register that restarts the countdown, a one- or two-byte timeout, a one- or two-byte readback of the remaining seconds, and a sticky flag that records a watchdog-caused reset. The count advances on a one-millisecond tick pulse supplied from outside. The bus decoder in front of the window and the generator of the tick are not part of the block.

The parameter `FMT` selects how the timeout byte(s) are read: as a power-of-two exponent of ticks, as an 8-bit count of seconds, or as a 16-bit count of seconds. The parameter `MAIN_MODE` selects whether expiry drives a held reset request (main) or only raises an alarm flag (auxiliary). `TPS` sets how many ticks make one second.

Top module: `wdog_core`

Register addresses: 0 control, 1 kick, 2 timeout low byte, 3 timeout high byte, 4 time-left low byte, 5 time-left high byte, 6 cause. Unused addresses read 0.

## Requirements
- R1: After `rst_ni` is released the control byte reads 0, the timeout reads `TMO_RESET`, time left reads 0, and both `wdog_rst_o` and `alarm_o` are low.
- R2: Writing the control byte (address 0) stores all eight bits and reads them back; bit 0 = 1 lets the countdown run one step per qualifying tick, bit 0 = 0 freezes the countdown where it is.
- R3: A write to address 0 that moves bit 0 from 0 to 1, or a write to address 1 with data bit 0 = 1, reloads the full period; a write to address 1 with bit 0 = 0 changes nothing.
- R4: In exponent format bits [3:0] of the timeout low byte give n, and the period is 2^n ticks, with n raised to ceil(log2 `TPS`) when smaller and limited to `EXP_MAX`; both time-left addresses read 0.
- R5: In 8-bit format the period is T x `TPS` ticks for the timeout byte T; T = 0 behaves as 1; address 3 and address 5 read 0 and writes to address 3 have no effect.
- R6: In 16-bit format the timeout is {address 3, address 2} and the period is T x `TPS` ticks, with T = 0 behaving as 1.
- R7: In the seconds formats address 4 reads the low byte of the remaining seconds rounded up; in 16-bit format a read strobe on address 4 captures the high byte, and address 5 returns that captured byte until the next such read.
- R8: A timeout written while the timer runs does not alter the running countdown; it is used at the next reload.
- R9: In main mode the step that brings the countdown to zero sets `wdog_rst_o`, which stays high until `rst_ni` is asserted; `alarm_o` stays low.
- R10: In main mode expiry sets bit 0 of address 6; the bit survives `rst_ni`, is cleared by `por_ni` or by writing 1 to bit 0 of address 6, and a set in the same cycle wins.
- R11: In auxiliary mode expiry sets `alarm_o` and never `wdog_rst_o`; the alarm clears on a reload or on a control write with bit 0 = 0.
- R12: After expiry the countdown stays at zero and time left reads 0 until a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of everything except the cause flag |
| por_ni | input | 1 | Asynchronous active-low power-on reset of the cause flag |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (only used to capture the time-left high byte) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| wdog_rst_o | output | 1 | Held reset request on expiry (main mode) |
| alarm_o | output | 1 | Alarm flag on expiry (auxiliary mode) |

## Verification
The assertions assume that `bus_wr_i` and `bus_rd_i` are single-cycle strobes with a stable address and that `TMO_RESET` and every programmed timeout give a non-zero reload, which the reload calculator guarantees by clamping. They further assume the timer is armed only through a control write, so that the count is never left at zero while running without a reload. The stimulus drives each strobe for exactly one clock with tick held low, drives ticks as bursts on otherwise idle cycles, and shares one bus across three configurations so that every format and both expiry modes see the same sequence.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        FMT_EXP2  = 2'd0,
        FMT_SEC8  = 2'd1,
        FMT_SEC16 = 2'd2
    } tmo_fmt_e;

    localparam logic [2:0] ADR_CTRL    = 3'd0;
    localparam logic [2:0] ADR_KICK    = 3'd1;
    localparam logic [2:0] ADR_TMO_LO  = 3'd2;
    localparam logic [2:0] ADR_TMO_HI  = 3'd3;
    localparam logic [2:0] ADR_LEFT_LO = 3'd4;
    localparam logic [2:0] ADR_LEFT_HI = 3'd5;
    localparam logic [2:0] ADR_CAUSE   = 3'd6;

endpackage

// File: rtl/wdog_reload_calc.sv
module wdog_reload_calc
    import wdog_pkg::*;
#(
    parameter tmo_fmt_e FMT     = FMT_SEC8,
    parameter int       EXP_MIN = 10,
    parameter int       EXP_MAX = 15,
    parameter int       CW      = 16
) (
    input  logic [15:0]   tmo_i,
    output logic [CW-1:0] reload_o
);

    localparam int EW = $clog2(EXP_MAX + 1);

    generate
        if (FMT == FMT_EXP2) begin : g_exp
            localparam logic [EW-1:0] N_LO = EW'(EXP_MIN);
            localparam logic [EW-1:0] N_HI = EW'(EXP_MAX);
            logic [EW-1:0] n_raw;
            logic [EW-1:0] n_use;
            logic          unused_hi;

            assign n_raw     = tmo_i[EW-1:0];
            assign unused_hi = ^tmo_i[15:EW];

            always_comb begin
                if (n_raw < N_LO) begin
                    n_use = N_LO;
                end else if (n_raw > N_HI) begin
                    n_use = N_HI;
                end else begin
                    n_use = n_raw;
                end
                reload_o = CW'(1) << n_use;
            end
        end else begin : g_sec
            logic [15:0] secs;

            if (FMT == FMT_SEC8) begin : g_byte
                logic unused_hi;
                assign unused_hi = ^tmo_i[15:8];
                assign secs      = {8'h00, tmo_i[7:0]};
            end else begin : g_word
                assign secs = tmo_i;
            end

            always_comb begin
                if (secs == 16'd0) begin
                    reload_o = CW'(1);
                end else begin
                    reload_o = CW'(secs);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter tmo_fmt_e FMT = FMT_SEC8,
    parameter int       TPS = 1000,
    parameter int       CW  = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);

    localparam int            PW       = (TPS > 1) ? $clog2(TPS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TPS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pre;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step;
    logic    active;

    assign active = run_i && (st_q.cnt != '0) && tick_i;

    generate
        if (FMT == FMT_EXP2) begin : g_tick_step
            assign step = tick_i;
        end else begin : g_sec_step
            assign step = tick_i && (st_q.pre == PRE_LAST);
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
            st_d.pre = '0;
        end else if (active) begin
            if (FMT != FMT_EXP2) begin
                st_d.pre = step ? '0 : st_q.pre + 1'b1;
            end
            if (step) begin
                st_d.cnt = st_q.cnt - 1'b1;
                expire_o = (st_q.cnt == CW'(1));
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter tmo_fmt_e    FMT       = FMT_SEC8,
    parameter bit          MAIN_MODE = 1'b1,
    parameter int          TPS       = 1000,
    parameter int          EXP_MAX   = 15,
    parameter logic [15:0] TMO_RESET = 16'd15
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       por_ni,
    input  logic       tick_i,
    input  logic       bus_wr_i,
    input  logic       bus_rd_i,
    input  logic [2:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       wdog_rst_o,
    output logic       alarm_o
);

    localparam int EXP_MIN = (TPS > 1) ? $clog2(TPS) : 0;
    localparam int CW      = (EXP_MAX + 1 > 16) ? EXP_MAX + 1 : 16;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] tmo;
        logic [7:0]  left_hi;
        logic        bite;
        logic        alarm;
    } regs_t;

    regs_t         r_d, r_q;
    logic          cause_d, cause_q;
    logic          wr_ctrl;
    logic          kick;
    logic          en_rise;
    logic          en_off;
    logic          load_s;
    logic          run_s;
    logic          expire_s;
    logic [CW-1:0] reload_s;
    logic [CW-1:0] cnt_s;
    logic [15:0]   secs_left;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == ADR_CTRL);
    assign kick    = bus_wr_i && (bus_addr_i == ADR_KICK) && bus_wdata_i[0];
    assign en_rise = wr_ctrl && bus_wdata_i[0] && !r_q.ctrl[0];
    assign en_off  = wr_ctrl && !bus_wdata_i[0];
    assign load_s  = kick || en_rise;
    assign run_s   = r_q.ctrl[0];

    wdog_reload_calc #(
        .FMT     (FMT),
        .EXP_MIN (EXP_MIN),
        .EXP_MAX (EXP_MAX),
        .CW      (CW)
    ) i_reload (
        .tmo_i    (r_q.tmo),
        .reload_o (reload_s)
    );

    wdog_counter #(
        .FMT (FMT),
        .TPS (TPS),
        .CW  (CW)
    ) i_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_i      (run_s),
        .load_i     (load_s),
        .load_val_i (reload_s),
        .cnt_o      (cnt_s),
        .expire_o   (expire_s)
    );

    generate
        if (FMT == FMT_EXP2) begin : g_no_left
            logic unused_cnt;
            assign unused_cnt = ^cnt_s;
            assign secs_left  = 16'd0;
        end else begin : g_left
            if (CW > 16) begin : g_wide
                logic unused_cnt;
                assign unused_cnt = ^cnt_s[CW-1:16];
            end
            assign secs_left = cnt_s[15:0];
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl = bus_wdata_i;
        end
        if (bus_wr_i && (bus_addr_i == ADR_TMO_LO)) begin
            r_d.tmo[7:0] = bus_wdata_i;
        end
        if ((FMT == FMT_SEC16) && bus_wr_i && (bus_addr_i == ADR_TMO_HI)) begin
            r_d.tmo[15:8] = bus_wdata_i;
        end
        if ((FMT == FMT_SEC16) && bus_rd_i && (bus_addr_i == ADR_LEFT_LO)) begin
            r_d.left_hi = secs_left[15:8];
        end
        if (MAIN_MODE) begin
            if (expire_s) begin
                r_d.bite = 1'b1;
            end
        end else begin
            if (expire_s) begin
                r_d.alarm = 1'b1;
            end else if (load_s || en_off) begin
                r_d.alarm = 1'b0;
            end
        end
    end

    always_comb begin
        cause_d = cause_q;
        if (bus_wr_i && (bus_addr_i == ADR_CAUSE) && bus_wdata_i[0]) begin
            cause_d = 1'b0;
        end
        if (MAIN_MODE && expire_s) begin
            cause_d = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q         <= '0;
            r_q.tmo     <= TMO_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            cause_q <= 1'b0;
        end else if (rst_ni) begin
            cause_q <= cause_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADR_CTRL:    bus_rdata_o = r_q.ctrl;
            ADR_TMO_LO:  bus_rdata_o = r_q.tmo[7:0];
            ADR_TMO_HI:  bus_rdata_o = (FMT == FMT_SEC16) ? r_q.tmo[15:8] : 8'h00;
            ADR_LEFT_LO: bus_rdata_o = secs_left[7:0];
            ADR_LEFT_HI: bus_rdata_o = (FMT == FMT_SEC16) ? r_q.left_hi : 8'h00;
            ADR_CAUSE:   bus_rdata_o = {7'b0, cause_q};
            default:     bus_rdata_o = 8'h00;
        endcase
    end

    assign wdog_rst_o = r_q.bite;
    assign alarm_o    = r_q.alarm;

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter bit MAIN_MODE = 1'b1,
    parameter int CW        = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          bus_wr_i,
    input logic [2:0]    bus_addr_i,
    input logic [7:0]    bus_wdata_i,
    input logic          wdog_rst_o,
    input logic          alarm_o,
    input logic          cause_q,
    input logic          load_s,
    input logic          run_s,
    input logic [CW-1:0] cnt_s
);

    // R9: the reset request is held once raised
    a_r9_bite_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_o |=> wdog_rst_o);

    // R10: the cause flag is set together with a new reset request
    a_r10_cause_with_bite: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (MAIN_MODE && $rose(wdog_rst_o)) |-> cause_q);

    // R2: a stopped timer holds its count
    a_r2_frozen_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_s && !load_s) |=> $stable(cnt_s));

    // R3: a reload always leaves a non-zero count
    a_r3_reload_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_s |=> (cnt_s != '0));

    // R12: an expired count stays at zero without a reload
    a_r12_zero_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt_s == '0) && !load_s) |=> (cnt_s == '0));

    // R11: a kick clears the alarm
    a_r11_kick_clears_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (bus_addr_i == 3'd1) && bus_wdata_i[0]) |=> !alarm_o);

    // R11: an alarm rises only on an exhausted count
    a_r11_alarm_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alarm_o) |-> (cnt_s == '0));

endmodule

bind wdog_core wdog_core_chk #(
    .MAIN_MODE (MAIN_MODE),
    .CW        (CW)
) i_wdog_core_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .wdog_rst_o  (wdog_rst_o),
    .alarm_o     (alarm_o),
    .cause_q     (cause_q),
    .load_s      (load_s),
    .run_s       (run_s),
    .cnt_s       (cnt_s)
);

// File: tb/wdog_ref.sv
module wdog_ref #(
    parameter int          FMT       = 1,
    parameter int          MAIN      = 1,
    parameter int          TPS       = 1000,
    parameter int          EXP_MAX   = 15,
    parameter logic [15:0] TMO_RESET = 16'd15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       tick,
    input  logic       wr,
    input  logic       rd,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       bite,
    output logic       alarm
);

    int          left;
    logic [7:0]  act;
    logic [15:0] tmo;
    logic [7:0]  hil;
    logic        cause;

    function automatic int period();
        int n;
        int t;
        if (FMT == 0) begin
            n = int'(tmo) % (1 << $clog2(EXP_MAX + 1));
            if (n < $clog2(TPS)) n = $clog2(TPS);
            if (n > EXP_MAX) n = EXP_MAX;
            return 1 << n;
        end
        t = (FMT == 1) ? int'(tmo[7:0]) : int'(tmo);
        if (t == 0) t = 1;
        return t * TPS;
    endfunction

    function automatic int secs();
        return (FMT == 0) ? 0 : (left + TPS - 1) / TPS;
    endfunction

    always @(posedge clk) begin
        if (!por_n) cause <= 1'b0;
        if (!rst_n) begin
            left  <= 0;
            act   <= 8'h00;
            tmo   <= TMO_RESET;
            hil   <= 8'h00;
            bite  <= 1'b0;
            alarm <= 1'b0;
        end else begin
            if (por_n && wr && addr == 3'd6 && wdata[0]) cause <= 1'b0;
            if (wr && addr == 3'd0) begin
                act <= wdata;
                if (!wdata[0]) alarm <= 1'b0;
            end
            if (wr && addr == 3'd2) tmo[7:0] <= wdata;
            if (wr && addr == 3'd3 && FMT == 2) tmo[15:8] <= wdata;
            if (rd && addr == 3'd4 && FMT == 2) hil <= 8'(secs() >> 8);
            if ((wr && addr == 3'd1 && wdata[0]) || (wr && addr == 3'd0 && wdata[0] && !act[0])) begin
                left  <= period();
                alarm <= 1'b0;
            end else if (act[0] && left > 0 && tick) begin
                left <= left - 1;
                if (left == 1) begin
                    if (MAIN != 0) begin
                        bite  <= 1'b1;
                        cause <= 1'b1;
                    end else begin
                        alarm <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = act;
            3'd2:    rdata = tmo[7:0];
            3'd3:    rdata = (FMT == 2) ? tmo[15:8] : 8'h00;
            3'd4:    rdata = 8'(secs());
            3'd5:    rdata = (FMT == 2) ? hil : 8'h00;
            3'd6:    rdata = {7'b0, (MAIN != 0) ? cause : 1'b0};
            default: rdata = 8'h00;
        endcase
    end

endmodule

// File: tb/test_wdog_core.sv
`timescale 1ns/1ps
module test_wdog_core;
    import wdog_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;

    logic [7:0] rd_a, rd_b, rd_c, m_rd_a, m_rd_b, m_rd_c;
    logic       rst_a, rst_b, rst_c, m_rst_a, m_rst_b, m_rst_c;
    logic       al_a, al_b, al_c, m_al_a, m_al_b, m_al_c;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // A: exponent format, main mode
    wdog_core #(.FMT(FMT_EXP2), .MAIN_MODE(1'b1), .TPS(4)) i_wdog_core (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rd_a), .wdog_rst_o(rst_a), .alarm_o(al_a));
    // B: 8-bit seconds, auxiliary mode
    wdog_core #(.FMT(FMT_SEC8), .MAIN_MODE(1'b0), .TPS(4)) i_wdog_core_b (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rd_b), .wdog_rst_o(rst_b), .alarm_o(al_b));
    // C: 16-bit seconds, main mode
    wdog_core #(.FMT(FMT_SEC16), .MAIN_MODE(1'b1), .TPS(3)) i_wdog_core_c (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rd_c), .wdog_rst_o(rst_c), .alarm_o(al_c));

    wdog_ref #(.FMT(0), .MAIN(1), .TPS(4)) i_ref_a (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .wr(wr), .rd(rd),
        .addr(addr), .wdata(wdata), .rdata(m_rd_a), .bite(m_rst_a), .alarm(m_al_a));
    wdog_ref #(.FMT(1), .MAIN(0), .TPS(4)) i_ref_b (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .wr(wr), .rd(rd),
        .addr(addr), .wdata(wdata), .rdata(m_rd_b), .bite(m_rst_b), .alarm(m_al_b));
    wdog_ref #(.FMT(2), .MAIN(1), .TPS(3)) i_ref_c (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .wr(wr), .rd(rd),
        .addr(addr), .wdata(wdata), .rdata(m_rd_c), .bite(m_rst_c), .alarm(m_al_c));

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R6";
            3'd4, 3'd5: return "R7";
            3'd6: return "R10";
            default: return "R1";
        endcase
    endfunction

    // reference model comparison on every clock
    always @(negedge clk) begin
        #3;
        if (rst_n && por_n && !done) begin
            chk(req_of(addr), "model rdata A", int'(rd_a), int'(m_rd_a));
            chk(req_of(addr), "model rdata B", int'(rd_b), int'(m_rd_b));
            chk(req_of(addr), "model rdata C", int'(rd_c), int'(m_rd_c));
            chk("R9", "model rst A", int'(rst_a), int'(m_rst_a));
            chk("R11", "model rst B", int'(rst_b), int'(m_rst_b));
            chk("R9", "model rst C", int'(rst_c), int'(m_rst_c));
            chk("R9", "model alarm A", int'(al_a), int'(m_al_a));
            chk("R11", "model alarm B", int'(al_b), int'(m_al_b));
            chk("R9", "model alarm C", int'(al_c), int'(m_al_c));
        end
    end

    task automatic wrb(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rdb(input logic [2:0] a, input int ea, input int eb, input int ec, input string req);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        if (ea >= 0) chk(req, "read A", int'(rd_a), ea);
        if (eb >= 0) chk(req, "read B", int'(rd_b), eb);
        if (ec >= 0) chk(req, "read C", int'(rd_c), ec);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pins(input int ra, input int rb, input int rc, input int aa, input int ab, input int ac, input string req);
        #1;
        chk(req, "rst A", int'(rst_a), ra);
        chk(req, "rst B", int'(rst_b), rb);
        chk(req, "rst C", int'(rst_c), rc);
        chk(req, "alarm A", int'(al_a), aa);
        chk(req, "alarm B", int'(al_b), ab);
        chk(req, "alarm C", int'(al_c), ac);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R1: state after reset
        pins(0, 0, 0, 0, 0, 0, "R1");
        rdb(3'd0, 0, 0, 0, "R1");
        rdb(3'd2, 15, 15, 15, "R1");
        rdb(3'd3, 0, 0, 0, "R1");
        rdb(3'd4, 0, 0, 0, "R1");

        // R2 / R3: arm with timeout 5 (A 32 ticks, B 20, C 15)
        wrb(3'd2, 8'h05);
        wrb(3'd0, 8'hA1);
        rdb(3'd0, 8'hA1, 8'hA1, 8'hA1, "R2");
        rdb(3'd4, 0, 5, 5, "R4");
        ticks(7);
        rdb(3'd4, 0, 4, 3, "R7");
        wrb(3'd1, 8'h01);
        rdb(3'd4, 0, 5, 5, "R3");
        ticks(3);
        rdb(3'd4, 0, 5, 4, "R3");
        wrb(3'd1, 8'h02);
        rdb(3'd4, 0, 5, 4, "R3");

        // R2: stopped timer holds
        wrb(3'd0, 8'hA0);
        ticks(10);
        rdb(3'd4, 0, 5, 4, "R2");
        rdb(3'd0, 8'hA0, 8'hA0, 8'hA0, "R2");

        // R8 / R9 / R11 / R12: timeout 2 (A 4 ticks, B 8, C 6)
        wrb(3'd2, 8'h02);
        wrb(3'd0, 8'h01);
        wrb(3'd2, 8'h09);
        rdb(3'd4, 0, 2, 2, "R8");
        ticks(3);
        pins(0, 0, 0, 0, 0, 0, "R4");
        ticks(1);
        pins(1, 0, 0, 0, 0, 0, "R9");
        ticks(2);
        pins(1, 0, 1, 0, 0, 0, "R9");
        rdb(3'd6, 1, 0, 1, "R10");
        ticks(2);
        pins(1, 0, 1, 0, 1, 0, "R11");
        rdb(3'd4, 0, 0, 0, "R12");
        ticks(5);
        rdb(3'd4, 0, 0, 0, "R12");
        wrb(3'd1, 8'h01);
        pins(1, 0, 1, 0, 0, 0, "R11");
        rdb(3'd4, 0, 9, 9, "R8");

        // R10: cause survives rst_n, cleared by write of 1
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        pins(0, 0, 0, 0, 0, 0, "R9");
        rdb(3'd6, 1, 0, 1, "R10");
        wrb(3'd6, 8'h01);
        rdb(3'd6, 0, 0, 0, "R10");

        // R5 / R6 / R7: 16-bit timeout 300 s in C, 44 s in B
        wrb(3'd2, 8'h2C);
        wrb(3'd3, 8'h01);
        rdb(3'd3, 0, 0, 1, "R5");
        wrb(3'd0, 8'h01);
        rdb(3'd4, 0, 8'h2C, 8'h2C, "R6");
        rdb(3'd5, 0, 0, 1, "R7");
        ticks(135);
        rdb(3'd5, 0, 0, 1, "R7");
        rdb(3'd4, 0, 8'h0B, 8'hFF, "R7");
        rdb(3'd5, 0, 0, 0, "R7");

        // R4 / R5 / R6: zero timeout behaves as the minimum
        wrb(3'd2, 8'h00);
        wrb(3'd3, 8'h00);
        wrb(3'd0, 8'h00);
        wrb(3'd0, 8'h01);
        rdb(3'd4, 0, 1, 1, "R5");
        ticks(2);
        pins(0, 0, 0, 0, 0, 0, "R6");
        ticks(1);
        pins(0, 0, 1, 0, 0, 0, "R6");
        ticks(1);
        pins(1, 0, 1, 0, 1, 0, "R4");

        // R10: power-on reset clears the cause flag
        @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
        rdb(3'd6, 0, 0, 0, "R10");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule